// File: doc/BRIEF.md
# Management-mode entry and resume sequencer

This block sits beside a simple processor core and decides when the core leaves ordinary execution for an isolated management mode, and when it comes back. A dedicated management interrupt is the only way in. The block waits for an instruction boundary, masks ordinary interrupts and saves the core's context words into a protected memory region. It then forces real-address operation with paging off and raises the mode flag so the core can start the handler.

The handler ends by executing a resume instruction. The core's decoder reports it on a strobe. The block then reads the saved words back into the core's context and hands back the protection and paging settings that were in force before entry. Finally it unmasks interrupts. A resume decoded outside the mode is flagged as an illegal instruction. Accesses to the protected region are granted only while the mode is active. A management request that arrives while the block is busy is kept pending and taken at the first boundary after the return.

Top module: `mgmt_mode_ctrl`

## Requirements
- R1: After a synchronous reset the block is in normal mode with `active_o`, `imask_o`, `mem_valid_o`, `cr_load_o`, `illegal_o`, `acc_grant_o` and `acc_deny_o` all low, and no request pending.
- R2: Normal mode is left only when a request is seen (`smi_req_i` high now or latched earlier) in a cycle with `boundary_i` high. A request seen without a boundary is held and taken at the next boundary. `imask_o` rises in the cycle after that boundary edge.
- R3: The save writes CTX_WORDS words, one per accepted handshake (`mem_valid_o` and `mem_ready_i` both high, `mem_we_o` high). Word i is the core word at `ctx_idx_o` = i, written at address BASE_ADDR+i. The index advances only when `mem_ready_i` is high. `active_o` rises in the cycle after the last write is accepted, and no region transfer runs while `active_o` is high.
- R4: Together with `active_o` rising, `cr_load_o` pulses for one cycle with `cr_pe_o` = 0 and `cr_pg_o` = 0.
- R5: `imask_o` stays high from entry until the restore completes, and it is high whenever `active_o` is.
- R6: A resume strobe seen while `active_o` is low raises `illegal_o` for the next cycle and changes no mode state.
- R7: A resume strobe seen while `active_o` is high starts the restore. This reads addresses BASE_ADDR+i in order, with `mem_we_o` low, and presents each accepted word on `ctx_wdata_o`, with `ctx_we_o` high and `ctx_idx_o` = i. After the last word, `cr_load_o` pulses with the protection and paging values sampled on `cr_pe_i`/`cr_pg_i` at entry, and `imask_o` falls.
- R8: A protected-region access request gives `acc_grant_o` in the next cycle when `active_o` was high, and `acc_deny_o` otherwise.
- R9: A request seen during save, active or restore does not nest. It is serviced at the first boundary after the return to normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smi_req_i | input | 1 | Management interrupt request |
| boundary_i | input | 1 | Instruction boundary strobe |
| resume_i | input | 1 | Decoded resume instruction strobe |
| cr_pe_i | input | 1 | Core's current protection-enable bit |
| cr_pg_i | input | 1 | Core's current paging-enable bit |
| ctx_in_i | input | DATA_W | Core context word selected by ctx_idx_o |
| ctx_idx_o | output | CNT_W | Context word index for save and restore |
| ctx_we_o | output | 1 | Restore write strobe into core context |
| ctx_wdata_o | output | DATA_W | Restored context word |
| mem_valid_o | output | 1 | Protected-region transfer request |
| mem_we_o | output | 1 | Transfer is a write (save) |
| mem_addr_o | output | ADDR_W | Protected-region word address |
| mem_wdata_o | output | DATA_W | Save data |
| mem_ready_i | input | 1 | Region accepts the transfer |
| mem_rdata_i | input | DATA_W | Region read data, valid with ready |
| acc_req_i | input | 1 | Core access request to the protected region |
| acc_grant_o | output | 1 | Access granted (registered) |
| acc_deny_o | output | 1 | Access denied (registered) |
| active_o | output | 1 | Management mode active, handler may run |
| imask_o | output | 1 | Ordinary interrupt mask |
| cr_load_o | output | 1 | Core must load cr_pe_o/cr_pg_o this cycle |
| cr_pe_o | output | 1 | Protection-enable value to load |
| cr_pg_o | output | 1 | Paging-enable value to load |
| illegal_o | output | 1 | Illegal resume instruction flag |

## Verification
The bench builds the block with CTX_WORDS = 5, ADDR_W = 6 and BASE_ADDR = 8. The context length is not a power of two, so the last-word compare is exercised at a count below the counter's natural wrap. The nonzero base offset shows up on every region address. The region is small enough for the bench to model it whole, so random handler writes to the saved words between entry and resume show up in the restored context. Random stalls on the ready line reach held save and restore words, and requests, resumes and accesses are thrown at every state.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_SAVE    = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_RESTORE = 2'd3
  } mstate_t;
endpackage

// File: rtl/mgmt_fsm.sv
module mgmt_fsm
  import mgmt_pkg::*;
#(
  parameter int CTX_WORDS = 8,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smi_req_i,
  input  logic             boundary_i,
  input  logic             resume_i,
  input  logic             mem_ready_i,
  output mstate_t          state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             enter_o,
  output logic             save_done_o,
  output logic             rest_done_o
);
  mstate_t          state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             last;

  assign last        = (int'(cnt_q) == CTX_WORDS - 1);
  assign enter_o     = (state_q == ST_NORMAL) && boundary_i && (smi_req_i || pend_q);
  assign save_done_o = (state_q == ST_SAVE) && mem_ready_i && last;
  assign rest_done_o = (state_q == ST_RESTORE) && mem_ready_i && last;
  assign state_o     = state_q;
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_NORMAL;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q | smi_req_i) & ~enter_o;
      case (state_q)
        ST_NORMAL: if (enter_o) begin
          state_q <= ST_SAVE;
          cnt_q   <= '0;
        end
        ST_SAVE: if (mem_ready_i) begin
          cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
          if (last) state_q <= ST_ACTIVE;
        end
        ST_ACTIVE: if (resume_i) begin
          state_q <= ST_RESTORE;
          cnt_q   <= '0;
        end
        default: if (mem_ready_i) begin
          cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
          if (last) state_q <= ST_NORMAL;
        end
      endcase
    end
  end

  // R3: the word counter never leaves the context range
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) < CTX_WORDS);
  // R3: without ready the transfer index holds
  a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SAVE || state_q == ST_RESTORE) && !mem_ready_i |=> $stable(cnt_q));
endmodule

// File: rtl/mgmt_crctl.sv
module mgmt_crctl (
  input  logic clk,
  input  logic rst,
  input  logic enter_i,
  input  logic save_done_i,
  input  logic rest_done_i,
  input  logic cr_pe_i,
  input  logic cr_pg_i,
  output logic imask_o,
  output logic cr_load_o,
  output logic cr_pe_o,
  output logic cr_pg_o
);
  logic saved_pe_q, saved_pg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      imask_o    <= 1'b0;
      cr_load_o  <= 1'b0;
      cr_pe_o    <= 1'b0;
      cr_pg_o    <= 1'b0;
      saved_pe_q <= 1'b0;
      saved_pg_q <= 1'b0;
    end else begin
      cr_load_o <= save_done_i | rest_done_i;
      if (enter_i) begin
        imask_o    <= 1'b1;
        saved_pe_q <= cr_pe_i;
        saved_pg_q <= cr_pg_i;
      end else if (rest_done_i) begin
        imask_o <= 1'b0;
      end
      if (save_done_i) begin
        cr_pe_o <= 1'b0;
        cr_pg_o <= 1'b0;
      end else if (rest_done_i) begin
        cr_pe_o <= saved_pe_q;
        cr_pg_o <= saved_pg_q;
      end
    end
  end

  // R7: the mask falls only together with the restoring control load
  a_r7_unmask_with_load: assert property (@(posedge clk) disable iff (rst)
    $fell(imask_o) |-> cr_load_o);
endmodule

// File: rtl/mgmt_gate.sv
module mgmt_gate (
  input  logic clk,
  input  logic rst,
  input  logic in_mode_i,
  input  logic resume_i,
  input  logic acc_req_i,
  output logic illegal_o,
  output logic acc_grant_o,
  output logic acc_deny_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      illegal_o   <= 1'b0;
      acc_grant_o <= 1'b0;
      acc_deny_o  <= 1'b0;
    end else begin
      illegal_o   <= resume_i && !in_mode_i;
      acc_grant_o <= acc_req_i && in_mode_i;
      acc_deny_o  <= acc_req_i && !in_mode_i;
    end
  end

  // R8: grant and deny are never given together
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(acc_grant_o && acc_deny_o));
endmodule

// File: rtl/mgmt_mode_ctrl.sv
module mgmt_mode_ctrl
  import mgmt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CTX_WORDS = 8,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 0,
  localparam int CNT_W    = (CTX_WORDS > 1) ? $clog2(CTX_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smi_req_i,
  input  logic              boundary_i,
  input  logic              resume_i,
  input  logic              cr_pe_i,
  input  logic              cr_pg_i,
  input  logic [DATA_W-1:0] ctx_in_i,
  output logic [CNT_W-1:0]  ctx_idx_o,
  output logic              ctx_we_o,
  output logic [DATA_W-1:0] ctx_wdata_o,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              acc_req_i,
  output logic              acc_grant_o,
  output logic              acc_deny_o,
  output logic              active_o,
  output logic              imask_o,
  output logic              cr_load_o,
  output logic              cr_pe_o,
  output logic              cr_pg_o,
  output logic              illegal_o
);
  mstate_t          state;
  logic [CNT_W-1:0] cnt;
  logic             enter, save_done, rest_done;

  mgmt_fsm #(.CTX_WORDS(CTX_WORDS), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .smi_req_i(smi_req_i), .boundary_i(boundary_i),
    .resume_i(resume_i), .mem_ready_i(mem_ready_i), .state_o(state),
    .cnt_o(cnt), .enter_o(enter), .save_done_o(save_done), .rest_done_o(rest_done)
  );

  mgmt_crctl u_cr (
    .clk(clk), .rst(rst), .enter_i(enter), .save_done_i(save_done),
    .rest_done_i(rest_done), .cr_pe_i(cr_pe_i), .cr_pg_i(cr_pg_i),
    .imask_o(imask_o), .cr_load_o(cr_load_o), .cr_pe_o(cr_pe_o), .cr_pg_o(cr_pg_o)
  );

  mgmt_gate u_gate (
    .clk(clk), .rst(rst), .in_mode_i(state == ST_ACTIVE), .resume_i(resume_i),
    .acc_req_i(acc_req_i), .illegal_o(illegal_o), .acc_grant_o(acc_grant_o),
    .acc_deny_o(acc_deny_o)
  );

  assign active_o    = (state == ST_ACTIVE);
  assign mem_valid_o = (state == ST_SAVE) || (state == ST_RESTORE);
  assign mem_we_o    = (state == ST_SAVE);
  assign mem_addr_o  = ADDR_W'(BASE_ADDR) + ADDR_W'(cnt);
  assign mem_wdata_o = ctx_in_i;
  assign ctx_idx_o   = cnt;
  assign ctx_we_o    = (state == ST_RESTORE) && mem_ready_i;
  assign ctx_wdata_o = mem_rdata_i;

  // R5: interrupts are masked throughout the active mode
  a_r5_mask_in_mode: assert property (@(posedge clk) disable iff (rst)
    active_o |-> imask_o);
  // R3: no region transfer runs while the handler owns the mode
  a_r3_quiet_when_active: assert property (@(posedge clk) disable iff (rst)
    active_o |-> !mem_valid_o);
  // R2: the mask can only rise after a boundary cycle
  a_r2_entry_at_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(imask_o) |-> $past(boundary_i));
  // R4: the entry load forces real-address operation with paging off
  a_r4_forced_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(active_o) |-> cr_load_o && !cr_pe_o && !cr_pg_o);
  // R6: a resume outside the mode is flagged next cycle
  a_r6_illegal_flag: assert property (@(posedge clk) disable iff (rst)
    resume_i && !active_o |=> illegal_o);
  // R8: a grant follows only a cycle with the mode active
  a_r8_grant_in_mode: assert property (@(posedge clk) disable iff (rst)
    acc_grant_o |-> $past(active_o));
endmodule

// File: tb/sim_mgmt_mode_ctrl.sv
`timescale 1ns/100ps
module sim_mgmt_mode_ctrl;
  localparam int DW = 32, NW = 5, AW = 6, BASE = 8, MSZ = 64, CW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic smi = 0, bnd = 0, res = 0, pe = 0, pg = 0, rdy = 0, acc = 0;
  logic [DW-1:0] ctx_in, mem_rd;
  logic [CW-1:0] ctx_idx;
  logic ctx_we, mem_valid, mem_we, acc_grant, acc_deny, active, imask, cr_load, cr_pe, cr_pg, illegal;
  logic [DW-1:0] ctx_wdata, mem_wdata;
  logic [AW-1:0] mem_addr;

  logic [DW-1:0] mem [MSZ];
  logic [DW-1:0] core_ctx [NW];
  int total = 0, bad = 0, cycles = 0;
  bit chk_on = 0;

  always #2 clk = ~clk;

  assign ctx_in = core_ctx[ctx_idx % NW];
  assign mem_rd = mem[mem_addr];

  mgmt_mode_ctrl #(.DATA_W(DW), .CTX_WORDS(NW), .ADDR_W(AW), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst(rst), .smi_req_i(smi), .boundary_i(bnd), .resume_i(res),
    .cr_pe_i(pe), .cr_pg_i(pg), .ctx_in_i(ctx_in), .ctx_idx_o(ctx_idx),
    .ctx_we_o(ctx_we), .ctx_wdata_o(ctx_wdata), .mem_valid_o(mem_valid),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ready_i(rdy), .mem_rdata_i(mem_rd), .acc_req_i(acc),
    .acc_grant_o(acc_grant), .acc_deny_o(acc_deny), .active_o(active),
    .imask_o(imask), .cr_load_o(cr_load), .cr_pe_o(cr_pe), .cr_pg_o(cr_pg),
    .illegal_o(illegal)
  );

  // reference model: 0 normal, 1 save, 2 active, 3 restore
  int m_st = 0, m_cnt = 0;
  bit m_pend = 0, m_mask = 0, m_spe = 0, m_spg = 0, m_load = 0, m_pe = 0, m_pg = 0;
  bit m_ill = 0, m_gr = 0, m_dn = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_pend = 0; m_mask = 0; m_load = 0; m_pe = 0; m_pg = 0;
      m_spe = 0; m_spg = 0; m_ill = 0; m_gr = 0; m_dn = 0;
    end else begin
      bit ent, sd, rd, lst;
      lst = (m_cnt == NW - 1);
      ent = (m_st == 0) && bnd && (smi || m_pend);
      sd  = (m_st == 1) && rdy && lst;
      rd  = (m_st == 3) && rdy && lst;
      m_ill = res && (m_st != 2);
      m_gr  = acc && (m_st == 2);
      m_dn  = acc && (m_st != 2);
      if (m_st == 1 && rdy) mem[(BASE + m_cnt) % MSZ] = core_ctx[m_cnt];
      if (m_st == 3 && rdy) core_ctx[m_cnt] = mem[(BASE + m_cnt) % MSZ];
      m_load = sd || rd;
      if (sd) begin m_pe = 0; m_pg = 0; end
      else if (rd) begin m_pe = m_spe; m_pg = m_spg; end
      if (ent) begin m_mask = 1; m_spe = pe; m_spg = pg; end
      else if (rd) m_mask = 0;
      m_pend = (m_pend || smi) && !ent;
      case (m_st)
        0: if (ent) begin m_st = 1; m_cnt = 0; end
        1: if (rdy) begin if (lst) begin m_st = 2; m_cnt = 0; end else m_cnt++; end
        2: if (res) begin m_st = 3; m_cnt = 0; end
        default: if (rdy) begin if (lst) begin m_st = 0; m_cnt = 0; end else m_cnt++; end
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on) begin
      chk(active == (m_st == 2), "R3", "active_o", active, m_st == 2);
      chk(imask == m_mask, "R5", "imask_o", imask, m_mask);
      chk(cr_load == m_load, "R4 R7", "cr_load_o", cr_load, m_load);
      chk({cr_pe, cr_pg} == {m_pe, m_pg}, "R4 R7", "cr_pe/pg", {cr_pe, cr_pg}, {m_pe, m_pg});
      chk(illegal == m_ill, "R6", "illegal_o", illegal, m_ill);
      chk({acc_grant, acc_deny} == {m_gr, m_dn}, "R8", "grant/deny", {acc_grant, acc_deny}, {m_gr, m_dn});
      #1;
      chk(mem_valid == (m_st == 1 || m_st == 3), "R3 R7", "mem_valid_o", mem_valid, m_st == 1 || m_st == 3);
      if (m_st == 1 || m_st == 3) begin
        chk(mem_we == (m_st == 1), "R3 R7", "mem_we_o", mem_we, m_st == 1);
        chk(int'(mem_addr) == (BASE + m_cnt) % MSZ, "R3 R7", "mem_addr_o", mem_addr, (BASE + m_cnt) % MSZ);
      end
      if (m_st == 1)
        chk(mem_wdata == core_ctx[m_cnt], "R3", "mem_wdata_o", mem_wdata, core_ctx[m_cnt]);
      chk(ctx_we == (m_st == 3 && rdy), "R7", "ctx_we_o", ctx_we, m_st == 3 && rdy);
      if (m_st == 3 && rdy) begin
        chk(int'(ctx_idx) == m_cnt, "R7", "ctx_idx_o", ctx_idx, m_cnt);
        chk(ctx_wdata == mem[(BASE + m_cnt) % MSZ], "R7", "ctx_wdata_o", ctx_wdata, mem[(BASE + m_cnt) % MSZ]);
      end
    end
  end

  task automatic cyc(input bit s, input bit b, input bit r, input bit y, input bit a);
    @(negedge clk); #0.5;
    smi = s; bnd = b; res = r; rdy = y; acc = a;
  endtask

  task automatic after_edge;
    @(posedge clk); #1;
  endtask

  initial begin
    for (int i = 0; i < MSZ; i++) mem[i] = $urandom;
    for (int i = 0; i < NW; i++) core_ctx[i] = 32'hC0DE_0000 + i;
    rst = 1;
    repeat (3) @(posedge clk);
    #0.5 rst = 0;
    after_edge();
    chk(!active && !imask && !mem_valid && !cr_load && !illegal && !acc_grant && !acc_deny,
        "R1", "reset outputs", {active, imask, mem_valid, cr_load, illegal}, 0);
    chk_on = 1;
    // R1: boundaries alone do not enter
    pe = 1; pg = 1;
    repeat (3) cyc(0, 1, 0, 1, 0);
    after_edge();
    chk(!imask, "R1", "no entry without request", imask, 0);
    // R2: request without boundary is held
    cyc(1, 0, 0, 1, 0);
    repeat (4) cyc(0, 0, 0, 1, 0);
    after_edge();
    chk(!imask, "R2", "no entry off boundary", imask, 0);
    cyc(0, 1, 0, 1, 0);
    after_edge();
    chk(imask && mem_valid, "R2", "entry at boundary", {imask, mem_valid}, 2'b11);
    pe = 0; pg = 0;
    repeat (NW) cyc(0, 0, 0, 1, 0);
    after_edge();
    chk(active && cr_load && !cr_pe && !cr_pg, "R4", "enter active", {active, cr_load, cr_pe, cr_pg}, 4'b1100);
    // R8: access inside the mode
    cyc(0, 0, 0, 1, 1);
    after_edge();
    chk(acc_grant && !acc_deny, "R8", "grant in mode", {acc_grant, acc_deny}, 2'b10);
    // R9: request during mode is pending, then resume
    cyc(1, 1, 0, 1, 0);
    after_edge();
    chk(active, "R9", "no nesting", active, 1);
    mem[BASE + 2] = 32'h1234_5678;
    cyc(0, 0, 1, 1, 0);
    repeat (NW) cyc(0, 0, 0, 1, 0);
    after_edge();
    chk(!imask && cr_load && cr_pe && cr_pg, "R7", "restore done", {imask, cr_load, cr_pe, cr_pg}, 4'b0111);
    chk(core_ctx[2] == 32'h1234_5678, "R7", "restored word", core_ctx[2], 32'h1234_5678);
    // R6: resume outside the mode
    cyc(0, 0, 1, 1, 1);
    after_edge();
    chk(illegal && !imask && acc_deny, "R6", "illegal resume", {illegal, imask, acc_deny}, 3'b101);
    cyc(0, 1, 0, 1, 0);
    after_edge();
    chk(imask, "R9", "pending serviced", imask, 1);
    // random phase
    for (int n = 0; n < 6000; n++) begin
      cyc(($urandom % 20) == 0, $urandom % 2, ($urandom % 8) == 0, ($urandom % 4) != 0, ($urandom % 4) == 0);
      pe = $urandom % 2; pg = $urandom % 2;
      if (m_st == 2 && ($urandom % 6) == 0) mem[(BASE + $urandom % NW) % MSZ] = $urandom;
    end
    cyc(0, 0, 0, 1, 0);
    @(negedge clk); #1.5;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule